// File: doc/BRIEF.md
# Processor exception entry unit

This block holds the control-register side of taking an exception. When the core raises a fault request, the unit takes the request together with the faulting program counter, the following program counter, and the live values of the status word, the cause word, the shadow-register-set control word and the saved exception PC. From these it works out the new contents of those four registers and the address of the handler. All of them are committed together one cycle later, along with a one-cycle redirect strobe.

A reset request gets its own treatment. The PC goes to the fixed reset address, the coprocessor-1 usable bit is set, and the other registers keep their values. Soft reset and non-maskable interrupt requests are not serviced: they only pulse an error flag. The pipeline flush, return from exception and interrupt arbitration stay with the surrounding core.

Top module: `exc_entry_unit`

## Requirements
- R1: Fault kinds syscall (0), reserved instruction (1), thread (2), overflow (3), trap (4), breakpoint (5), DSP disabled (6), machine check (7), coprocessor unusable (11), address error (13), TLB invalid (14), TLB refill (15) and TLB modified (16) redirect to base + 0x180. The base is 0xBFC00200 when status bit 22 (boot vectors) is 1, and 0x80000000 otherwise.
- R2: The interrupt kind (12) redirects to base + 0x000, with the base chosen as in R1.
- R3: Every serviced non-reset fault commits the status word with bit 1 (exception level) set to 1, whether or not it was already set. All other status bits are kept.
- R4: The shadow-set word changes only when status bits 1 and 22 were both 0. In that case bits [9:6] take the old bits [3:0], bits [3:0] take the old bits [15:12], and all other bits are kept. Otherwise the shadow-set word is kept unchanged.
- R5: A delay slot is present when the next PC differs from the current PC + 4. The saved exception PC is then the current PC − 4; otherwise it is the current PC.
- R6: On a serviced non-reset fault, cause bit 31 is written with the delay-slot flag and cause bits [6:2] with the code: syscall 8, reserved instruction 10, overflow 12, trap 13, breakpoint 9, machine check 24, coprocessor unusable 11, TLB modified 1, interrupt 0, and 0 for every other kind. All other cause bits are kept.
- R7: A reset request (kind 8) redirects to 0xBFC00000 and sets status bit 29. The cause, shadow-set and saved-PC words keep their previous committed values.
- R8: Soft reset (kind 9) and non-maskable interrupt (kind 10) pulse the unimplemented flag for one cycle. They raise no redirect and change no register output.
- R9: A fault sampled at a clock edge shows up on all outputs after that edge, with a redirect strobe one cycle wide. Register outputs hold their values when nothing is serviced.
- R10: A request sampled while the redirect strobe is high is ignored.
- R11: Kind codes 17 to 31 are ignored. No strobe, no flag and no register change result.
- R12: While reset is active, and until the first serviced fault, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fault_vld_i | input | 1 | Fault request valid |
| fault_kind_i | input | 5 | Encoded fault kind |
| cur_pc_i | input | 32 | PC of the faulting instruction |
| nxt_pc_i | input | 32 | PC that would have followed |
| status_i | input | 32 | Current status word |
| cause_i | input | 32 | Current cause word |
| srsctl_i | input | 32 | Current shadow-set control word |
| epc_i | input | 32 | Current saved exception PC |
| redirect_vld_o | output | 1 | One-cycle handler redirect strobe |
| redirect_pc_o | output | 32 | Handler address |
| status_o | output | 32 | Committed status word |
| cause_o | output | 32 | Committed cause word |
| srsctl_o | output | 32 | Committed shadow-set control word |
| epc_o | output | 32 | Committed saved exception PC |
| unimpl_o | output | 1 | Unimplemented-fault pulse |

## Verification
Two things can meet in one cycle: the commit of a serviced fault, seen as the redirect strobe, and the arrival of the next request. The directed back-to-back case drives a second fault in the very cycle the first one's strobe is high. Random stimulus keeps the request valid most of the time, so the same collision comes up often. In both cases the model expects the second request to leave every output unchanged and the strobe to drop, and only a request made one cycle later to be serviced.

// File: rtl/exc_pkg.sv
package exc_pkg;

  typedef enum logic [4:0] {
    FK_SYSCALL    = 5'd0,
    FK_RSVD_INSN  = 5'd1,
    FK_THREAD     = 5'd2,
    FK_OVERFLOW   = 5'd3,
    FK_TRAP       = 5'd4,
    FK_BREAK      = 5'd5,
    FK_DSP_OFF    = 5'd6,
    FK_MCHECK     = 5'd7,
    FK_RESET      = 5'd8,
    FK_SOFT_RST   = 5'd9,
    FK_NMI        = 5'd10,
    FK_COP_UNUSE  = 5'd11,
    FK_INTR       = 5'd12,
    FK_ADDR_ERR   = 5'd13,
    FK_TLB_INV    = 5'd14,
    FK_TLB_REFILL = 5'd15,
    FK_TLB_MOD    = 5'd16
  } fault_kind_e;

  typedef enum logic [1:0] {
    CLS_NONE   = 2'd0,
    CLS_NORMAL = 2'd1,
    CLS_RESET  = 2'd2,
    CLS_UNIMPL = 2'd3
  } fault_cls_e;

  // Bit positions the rest of the core decodes
  localparam int ST_EXL     = 1;
  localparam int ST_BEV     = 22;
  localparam int ST_CU1     = 29;
  localparam int CA_BD      = 31;
  localparam int CA_CODE_LO = 2;
  localparam int CA_CODE_W  = 5;
  localparam int SRS_W      = 4;
  localparam int SRS_CUR_LO = 0;
  localparam int SRS_PRV_LO = 6;
  localparam int SRS_EXC_LO = 12;

  typedef struct packed {
    fault_cls_e             cls;
    logic [CA_CODE_W-1:0]   code;
    logic                   gen_vec;  // 1: general offset, 0: zero offset
  } fault_info_t;

  // Committed word slots in the register bank
  localparam int SLOT_PC  = 0;
  localparam int SLOT_ST  = 1;
  localparam int SLOT_CA  = 2;
  localparam int SLOT_SRS = 3;
  localparam int SLOT_EPC = 4;
  localparam int NSLOT    = 5;

endpackage

// File: rtl/exc_fault_decode.sv
module exc_fault_decode
  import exc_pkg::*;
(
  input  logic [4:0]  kind_i,
  output fault_info_t info_o
);

  always_comb begin
    info_o.cls     = CLS_NORMAL;
    info_o.code    = '0;
    info_o.gen_vec = 1'b1;
    case (kind_i)
      FK_SYSCALL:    info_o.code = 5'd8;
      FK_RSVD_INSN:  info_o.code = 5'd10;
      FK_THREAD:     info_o.code = 5'd0;
      FK_OVERFLOW:   info_o.code = 5'd12;
      FK_TRAP:       info_o.code = 5'd13;
      FK_BREAK:      info_o.code = 5'd9;
      FK_DSP_OFF:    info_o.code = 5'd0;
      FK_MCHECK:     info_o.code = 5'd24;
      FK_COP_UNUSE:  info_o.code = 5'd11;
      FK_ADDR_ERR:   info_o.code = 5'd0;
      FK_TLB_INV:    info_o.code = 5'd0;
      FK_TLB_REFILL: info_o.code = 5'd0;
      FK_TLB_MOD:    info_o.code = 5'd1;
      FK_INTR: begin
        info_o.code    = 5'd0;
        info_o.gen_vec = 1'b0;
      end
      FK_RESET: begin
        info_o.cls     = CLS_RESET;
        info_o.gen_vec = 1'b0;
      end
      FK_SOFT_RST, FK_NMI: begin
        info_o.cls     = CLS_UNIMPL;
        info_o.gen_vec = 1'b0;
      end
      default: begin
        info_o.cls     = CLS_NONE;
        info_o.gen_vec = 1'b0;
      end
    endcase
  end

endmodule

// File: rtl/exc_state_calc.sv
module exc_state_calc
  import exc_pkg::*;
#(
  parameter int          XLEN          = 32,
  parameter int          INSN_BYTES    = 4,
  parameter logic [31:0] BASE_BOOT     = 32'hBFC0_0200,
  parameter logic [31:0] BASE_NORM     = 32'h8000_0000,
  parameter logic [31:0] RESET_VEC     = 32'hBFC0_0000,
  parameter logic [31:0] GEN_OFFSET    = 32'h0000_0180
) (
  input  fault_info_t       info_i,
  input  logic [XLEN-1:0]   cur_pc_i,
  input  logic [XLEN-1:0]   nxt_pc_i,
  input  logic [XLEN-1:0]   status_i,
  input  logic [XLEN-1:0]   cause_i,
  input  logic [XLEN-1:0]   srsctl_i,
  input  logic [XLEN-1:0]   epc_i,
  output logic [XLEN-1:0]   pc_o,
  output logic [XLEN-1:0]   status_o,
  output logic [XLEN-1:0]   cause_o,
  output logic [XLEN-1:0]   srsctl_o,
  output logic [XLEN-1:0]   epc_o
);

  localparam logic [XLEN-1:0] STEP = XLEN'(INSN_BYTES);

  logic            in_slot;
  logic            rotate;
  logic [XLEN-1:0] base;
  logic [XLEN-1:0] offset;
  logic [XLEN-1:0] rot_srs;
  logic [XLEN-1:0] upd_cause;

  assign in_slot = (nxt_pc_i != (cur_pc_i + STEP));
  assign rotate  = !status_i[ST_EXL] && !status_i[ST_BEV];
  assign base    = status_i[ST_BEV] ? XLEN'(BASE_BOOT) : XLEN'(BASE_NORM);
  assign offset  = info_i.gen_vec ? XLEN'(GEN_OFFSET) : '0;

  always_comb begin
    rot_srs = srsctl_i;
    rot_srs[SRS_PRV_LO +: SRS_W] = srsctl_i[SRS_CUR_LO +: SRS_W];
    rot_srs[SRS_CUR_LO +: SRS_W] = srsctl_i[SRS_EXC_LO +: SRS_W];
  end

  always_comb begin
    upd_cause = cause_i;
    upd_cause[CA_CODE_LO +: CA_CODE_W] = info_i.code;
    upd_cause[CA_BD] = in_slot;
  end

  always_comb begin
    pc_o     = base + offset;
    status_o = status_i;
    cause_o  = cause_i;
    srsctl_o = srsctl_i;
    epc_o    = epc_i;
    case (info_i.cls)
      CLS_NORMAL: begin
        status_o         = status_i;
        status_o[ST_EXL] = 1'b1;
        cause_o          = upd_cause;
        srsctl_o         = rotate ? rot_srs : srsctl_i;
        epc_o            = in_slot ? (cur_pc_i - STEP) : cur_pc_i;
      end
      CLS_RESET: begin
        pc_o             = XLEN'(RESET_VEC);
        status_o[ST_CU1] = 1'b1;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/exc_commit_reg.sv
module exc_commit_reg #(
  parameter int XLEN  = 32,
  parameter int NWORD = 5
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        load_i,
  input  logic                        unimpl_i,
  input  logic [NWORD-1:0][XLEN-1:0]  word_i,
  output logic                        strobe_o,
  output logic                        unimpl_o,
  output logic [NWORD-1:0][XLEN-1:0]  word_o
);

  logic strobe_d, unimpl_d;

  assign strobe_d = load_i;
  assign unimpl_d = unimpl_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      strobe_o <= 1'b0;
      unimpl_o <= 1'b0;
    end else begin
      strobe_o <= strobe_d;
      unimpl_o <= unimpl_d;
    end
  end

  for (genvar g = 0; g < NWORD; g++) begin : g_word
    logic [XLEN-1:0] d, q;
    always_comb d = load_i ? word_i[g] : q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= '0;
      else        q <= d;
    end
    assign word_o[g] = q;
  end

endmodule

// File: rtl/exc_entry_unit.sv
module exc_entry_unit
  import exc_pkg::*;
#(
  parameter int          XLEN       = 32,
  parameter int          INSN_BYTES = 4,
  parameter logic [31:0] BASE_BOOT  = 32'hBFC0_0200,
  parameter logic [31:0] BASE_NORM  = 32'h8000_0000,
  parameter logic [31:0] RESET_VEC  = 32'hBFC0_0000,
  parameter logic [31:0] GEN_OFFSET = 32'h0000_0180,
  parameter int          SYNC_DEPTH = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            fault_vld_i,
  input  logic [4:0]      fault_kind_i,
  input  logic [XLEN-1:0] cur_pc_i,
  input  logic [XLEN-1:0] nxt_pc_i,
  input  logic [XLEN-1:0] status_i,
  input  logic [XLEN-1:0] cause_i,
  input  logic [XLEN-1:0] srsctl_i,
  input  logic [XLEN-1:0] epc_i,
  output logic            redirect_vld_o,
  output logic [XLEN-1:0] redirect_pc_o,
  output logic [XLEN-1:0] status_o,
  output logic [XLEN-1:0] cause_o,
  output logic [XLEN-1:0] srsctl_o,
  output logic [XLEN-1:0] epc_o,
  output logic            unimpl_o
);

  // Reset: asserted asynchronously, released through a synchroniser
  logic [SYNC_DEPTH-1:0] rst_pipe;
  logic                  rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[SYNC_DEPTH-2:0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[SYNC_DEPTH-1];

  fault_info_t info;
  logic        accept;
  logic        load;
  logic        unimpl_req;
  logic [NSLOT-1:0][XLEN-1:0] nxt_word;
  logic [NSLOT-1:0][XLEN-1:0] cur_word;

  exc_fault_decode u_dec (
    .kind_i (fault_kind_i),
    .info_o (info)
  );

  exc_state_calc #(
    .XLEN       (XLEN),
    .INSN_BYTES (INSN_BYTES),
    .BASE_BOOT  (BASE_BOOT),
    .BASE_NORM  (BASE_NORM),
    .RESET_VEC  (RESET_VEC),
    .GEN_OFFSET (GEN_OFFSET)
  ) u_calc (
    .info_i   (info),
    .cur_pc_i (cur_pc_i),
    .nxt_pc_i (nxt_pc_i),
    .status_i (status_i),
    .cause_i  (cause_i),
    .srsctl_i (srsctl_i),
    .epc_i    (epc_i),
    .pc_o     (nxt_word[SLOT_PC]),
    .status_o (nxt_word[SLOT_ST]),
    .cause_o  (nxt_word[SLOT_CA]),
    .srsctl_o (nxt_word[SLOT_SRS]),
    .epc_o    (nxt_word[SLOT_EPC])
  );

  // A pending redirect blocks the next request
  assign accept     = fault_vld_i && !redirect_vld_o;
  assign load       = accept && (info.cls == CLS_NORMAL || info.cls == CLS_RESET);
  assign unimpl_req = accept && (info.cls == CLS_UNIMPL);

  exc_commit_reg #(
    .XLEN  (XLEN),
    .NWORD (NSLOT)
  ) u_regs (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .load_i   (load),
    .unimpl_i (unimpl_req),
    .word_i   (nxt_word),
    .strobe_o (redirect_vld_o),
    .unimpl_o (unimpl_o),
    .word_o   (cur_word)
  );

  assign redirect_pc_o = cur_word[SLOT_PC];
  assign status_o      = cur_word[SLOT_ST];
  assign cause_o       = cur_word[SLOT_CA];
  assign srsctl_o      = cur_word[SLOT_SRS];
  assign epc_o         = cur_word[SLOT_EPC];

endmodule

// File: rtl/exc_entry_checker.sv
module exc_entry_checker
  import exc_pkg::*;
#(
  parameter logic [31:0] RESET_VEC = 32'hBFC0_0000
) (
  input logic        clk,
  input logic        rst_n,
  input logic        fault_vld_i,
  input logic [4:0]  fault_kind_i,
  input logic [31:0] cur_pc_i,
  input logic [31:0] nxt_pc_i,
  input logic [31:0] status_i,
  input logic [31:0] srsctl_i,
  input logic        redirect_vld_o,
  input logic [31:0] redirect_pc_o,
  input logic [31:0] status_o,
  input logic [31:0] cause_o,
  input logic [31:0] srsctl_o,
  input logic [31:0] epc_o,
  input logic        unimpl_o
);

  logic acc, is_norm, is_rst, is_unimpl, is_bad;
  assign acc       = fault_vld_i && !redirect_vld_o;
  assign is_bad    = fault_kind_i > 5'd16;
  assign is_rst    = fault_kind_i == 5'd8;
  assign is_unimpl = fault_kind_i == 5'd9 || fault_kind_i == 5'd10;
  assign is_norm   = !is_bad && !is_rst && !is_unimpl;

  p_exl_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
    acc && is_norm |=> redirect_vld_o && status_o[ST_EXL]);

  p_srs_rotate_r4: assert property (@(posedge clk) disable iff (!rst_n)
    acc && is_norm && !status_i[ST_EXL] && !status_i[ST_BEV] |=>
      srsctl_o[3:0] == $past(srsctl_i[15:12]) && srsctl_o[9:6] == $past(srsctl_i[3:0]));

  p_epc_seq_r5: assert property (@(posedge clk) disable iff (!rst_n)
    acc && is_norm && (nxt_pc_i == cur_pc_i + 32'd4) |=>
      epc_o == $past(cur_pc_i) && !cause_o[CA_BD]);

  p_reset_entry_r7: assert property (@(posedge clk) disable iff (!rst_n)
    acc && is_rst |=> redirect_vld_o && redirect_pc_o == RESET_VEC && status_o[ST_CU1]);

  p_unimpl_r8: assert property (@(posedge clk) disable iff (!rst_n)
    acc && is_unimpl |=> unimpl_o && !redirect_vld_o && $stable(epc_o));

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !acc |=> !redirect_vld_o && !unimpl_o && $stable(status_o) && $stable(epc_o) && $stable(srsctl_o));

  p_single_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    redirect_vld_o |=> !redirect_vld_o);

  p_bad_kind_r11: assert property (@(posedge clk) disable iff (!rst_n)
    acc && is_bad |=> !redirect_vld_o && !unimpl_o && $stable(cause_o));

endmodule

bind exc_entry_unit exc_entry_checker #(.RESET_VEC(RESET_VEC)) u_chk (
  .clk            (clk),
  .rst_n          (rst_sync_n),
  .fault_vld_i    (fault_vld_i),
  .fault_kind_i   (fault_kind_i),
  .cur_pc_i       (cur_pc_i),
  .nxt_pc_i       (nxt_pc_i),
  .status_i       (status_i),
  .srsctl_i       (srsctl_i),
  .redirect_vld_o (redirect_vld_o),
  .redirect_pc_o  (redirect_pc_o),
  .status_o       (status_o),
  .cause_o        (cause_o),
  .srsctl_o       (srsctl_o),
  .epc_o          (epc_o),
  .unimpl_o       (unimpl_o)
);

// File: tb/exc_entry_unit_bench.sv
`timescale 1ns/1ps
module exc_entry_unit_bench;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        fault_vld;
  logic [4:0]  kind;
  logic [31:0] cur_pc, nxt_pc, st_i, ca_i, srs_i, epc_i;
  logic        rv_o, un_o;
  logic [31:0] pc_o, st_o, ca_o, srs_o, epc_o;

  int total = 0;
  int bad   = 0;

  // expected outputs
  logic        e_rv, e_un;
  logic [31:0] e_pc, e_st, e_ca, e_srs, e_epc;

  always #5 clk = ~clk;

  exc_entry_unit u_exc_entry_unit (
    .clk(clk), .rst_n(rst_n), .fault_vld_i(fault_vld), .fault_kind_i(kind),
    .cur_pc_i(cur_pc), .nxt_pc_i(nxt_pc), .status_i(st_i), .cause_i(ca_i),
    .srsctl_i(srs_i), .epc_i(epc_i), .redirect_vld_o(rv_o), .redirect_pc_o(pc_o),
    .status_o(st_o), .cause_o(ca_o), .srsctl_o(srs_o), .epc_o(epc_o), .unimpl_o(un_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [4:0] code_of(input logic [4:0] k);
    case (k)
      5'd0: return 5'd8;   5'd1: return 5'd10;  5'd3: return 5'd12;
      5'd4: return 5'd13;  5'd5: return 5'd9;   5'd7: return 5'd24;
      5'd11: return 5'd11; 5'd16: return 5'd1;
      default: return 5'd0;
    endcase
  endfunction

  // reference model: one clock step
  task automatic model();
    logic acc, slot, n_rv, n_un;
    logic [31:0] base;
    acc  = fault_vld && !e_rv;
    n_rv = 1'b0;
    n_un = 1'b0;
    base = st_i[22] ? 32'hBFC0_0200 : 32'h8000_0000;
    slot = (nxt_pc != cur_pc + 32'd4);
    if (acc) begin
      if (kind == 5'd8) begin
        n_rv = 1'b1;
        e_pc = 32'hBFC0_0000;
        e_st = st_i | 32'h2000_0000;
        e_ca = ca_i; e_srs = srs_i; e_epc = epc_i;
      end else if (kind == 5'd9 || kind == 5'd10) begin
        n_un = 1'b1;
      end else if (kind <= 5'd16) begin
        n_rv = 1'b1;
        e_pc = base + ((kind == 5'd12) ? 32'h0 : 32'h180);
        e_st = st_i | 32'h2;
        e_ca = {slot, ca_i[30:7], code_of(kind), ca_i[1:0]};
        e_srs = srs_i;
        if (!st_i[1] && !st_i[22])
          e_srs = {srs_i[31:10], srs_i[3:0], srs_i[5:4], srs_i[15:12]};
        e_epc = slot ? cur_pc - 32'd4 : cur_pc;
      end
    end
    e_rv = n_rv;
    e_un = n_un;
  endtask

  task automatic check_all(input string pc_tag);
    chk("R9 redirect_vld", {31'd0, rv_o}, {31'd0, e_rv});
    chk(pc_tag, pc_o, e_pc);
    chk("R3 status", st_o, e_st);
    chk("R6 cause", ca_o, e_ca);
    chk("R4 srsctl", srs_o, e_srs);
    chk("R5 epc", epc_o, e_epc);
    chk("R8 unimpl", {31'd0, un_o}, {31'd0, e_un});
  endtask

  // drive at a falling edge, wait one cycle, check
  task automatic step(input logic v, input logic [4:0] k, input logic [31:0] pc,
                      input logic [31:0] npc, input logic [31:0] st,
                      input logic [31:0] srs, input string pc_tag);
    fault_vld = v; kind = k; cur_pc = pc; nxt_pc = npc; st_i = st; srs_i = srs;
    ca_i = 32'h0000_FF00; epc_i = 32'h1111_2220;
    model();
    @(negedge clk);
    check_all(pc_tag);
  endtask

  initial begin
    #(200000 * 10);
    bad++;
    $display("FAIL watchdog act=running exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd2718));
    rst_n = 1'b0; fault_vld = 1'b0; kind = '0; cur_pc = '0; nxt_pc = '0;
    st_i = '0; ca_i = '0; srs_i = '0; epc_i = '0;
    e_rv = 0; e_un = 0; e_pc = 0; e_st = 0; e_ca = 0; e_srs = 0; e_epc = 0;
    repeat (3) @(negedge clk);
    check_all("R12 reset pc");
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check_all("R12 after release");

    // R1: syscall, sequential, normal base, rotation
    step(1, 5'd0, 32'h0000_1000, 32'h0000_1004, 32'h0000_0000, 32'h0000_5003, "R1 syscall pc");
    chk("R1 pc value", pc_o, 32'h8000_0180);
    chk("R6 code syscall", {27'd0, ca_o[6:2]}, 32'd8);
    chk("R4 rotated", srs_o, 32'h0000_50C5);
    step(0, 5'd0, 0, 4, 0, 0, "R9 idle");
    // R2: interrupt with boot vectors
    step(1, 5'd12, 32'h0000_2000, 32'h0000_2004, 32'h0040_0000, 32'h0000_7001, "R2 intr pc");
    chk("R2 pc value", pc_o, 32'hBFC0_0200);
    chk("R4 no rotate bev", srs_o, 32'h0000_7001);
    step(0, 5'd0, 0, 4, 0, 0, "R9 idle");
    // R5: delay slot, EXL already set
    step(1, 5'd3, 32'h0000_3000, 32'h0000_3040, 32'h0000_0002, 32'h0000_A001, "R1 ov pc");
    chk("R5 epc slot", epc_o, 32'h0000_2FFC);
    chk("R6 bd set", {31'd0, ca_o[31]}, 32'd1);
    chk("R3 exl kept", {31'd0, st_o[1]}, 32'd1);
    step(0, 5'd0, 0, 4, 0, 0, "R9 idle");
    // R7: reset entry
    step(1, 5'd8, 32'h0000_4000, 32'h0000_4004, 32'h0000_0000, 32'h0000_0001, "R7 reset pc");
    chk("R7 pc value", pc_o, 32'hBFC0_0000);
    chk("R7 cu1", {31'd0, st_o[29]}, 32'd1);
    step(0, 5'd0, 0, 4, 0, 0, "R9 idle");
    // R8: NMI
    step(1, 5'd10, 32'h0000_5000, 32'h0000_5004, 0, 0, "R8 nmi pc");
    chk("R8 flag", {31'd0, un_o}, 32'd1);
    // R11: undefined kind
    step(1, 5'd21, 32'h0000_6000, 32'h0000_6004, 0, 32'h0000_F00F, "R11 bad pc");
    chk("R11 no strobe", {31'd0, rv_o}, 32'd0);
    // R10: back-to-back
    step(1, 5'd4, 32'h0000_7000, 32'h0000_7004, 0, 0, "R1 trap pc");
    step(1, 5'd5, 32'h0000_8000, 32'h0000_8004, 0, 0, "R10 ignored pc");
    chk("R10 ignored epc", epc_o, 32'h0000_7000);
    chk("R10 strobe low", {31'd0, rv_o}, 32'd0);

    // random phase
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] pc, npc, st;
      logic [4:0] k;
      pc  = $urandom() & 32'hFFFF_FFFC;
      npc = ($urandom_range(1, 0) == 1) ? pc + 32'd4 : ($urandom() & 32'hFFFF_FFFC);
      st  = $urandom();
      k   = ($urandom_range(9, 0) == 0) ? 5'($urandom_range(31, 17)) : 5'($urandom_range(16, 0));
      fault_vld = ($urandom_range(3, 0) != 0);
      kind = k; cur_pc = pc; nxt_pc = npc; st_i = st;
      ca_i = $urandom(); srs_i = $urandom(); epc_i = $urandom();
      model();
      @(negedge clk);
      check_all("R1 R2 R7 random pc");
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule